// File: doc/BRIEF.md
# Bit-Tested Count-and-Stop Sequencer

The block is a small control-plus-datapath pair. It waits in an idle phase until a start request arrives. The start request clears a 4-bit counter and the finish flag. The block then enters a counting phase, where the counter advances by one on every clock. In each counting clock, two bits of the counter that is currently held control two things: a status flag is updated, and the block decides whether to leave the counting phase. When counting stops, the block spends one clock in a finish phase. In that clock it raises the finish flag, and then it goes back to idle.

The block suits a sequencer whose run length follows from fixed counter bits rather than from a programmable limit. From a cleared counter the run lasts 13 counting clocks. The current phase is made visible so that a surrounding controller can follow progress.

Top module: `bitstop_sequencer`

## Requirements
- R1: While rst_n is low, phase is 2'b00 (idle), count is 0, and both flag_e and flag_f are 0.
- R2: In idle with start low, phase, count, flag_e and flag_f all keep their values on the next clock.
- R3: In idle with start high, the next clock sets count to 0, flag_f to 0 and phase to 2'b01. flag_e keeps its value.
- R4: In the counting phase (2'b01), count increases by one on every clock.
- R5: In the counting phase, if bit 2 of the current count is 0, flag_e becomes 0 on the next clock and the phase stays 2'b01.
- R6: In the counting phase, if bit 2 of the current count is 1, flag_e becomes 1 on the next clock. The phase then moves to 2'b11 if bit 3 is 1, and otherwise stays 2'b01.
- R7: In the finish phase (2'b11), the next clock sets flag_f to 1, keeps count unchanged and returns phase to 2'b00.
- R8: phase only ever takes the codes 2'b00, 2'b01 and 2'b11. If the state register ever holds 2'b10, it goes to idle on the next clock.
- R9: A single start from idle gives exactly 13 clocks in the counting phase. The block then ends in idle with count 13, flag_e 1 and flag_f 1.
- R10: start has no effect outside the idle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| start | input | 1 | Start request, sampled in idle only |
| count | output | 4 | Counter value; bit 0 is the LSB |
| flag_e | output | 1 | Status flag that follows counter bit 2 during counting |
| flag_f | output | 1 | Finish flag, set in the finish phase and cleared by start |
| phase | output | 2 | Controller phase: 00 idle, 01 counting, 11 finish |

## Verification
The embedded assertions check every clock for the following single-step rules: holding in idle, the clear on start, the counter advancing by one, the flag_e update taken from bit 2, the exit taken from bits 2 and 3, the one-clock finish phase, and the absence of the unused code. The whole-run properties can only be shown by the bench scenarios, because each spans many cycles. These are the exact 13-clock run length and the final count and flag values. They also include start being ignored across a complete run when it is held high or toggled, flag_e carrying over into a second run, and an asynchronous reset arriving during counting.

// File: rtl/bitstop_pkg.sv
package bitstop_pkg;
  parameter int CNT_W = 4;
  localparam int FLAG_BIT = CNT_W - 2;
  localparam int STOP_BIT = CNT_W - 1;
  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_RUN  = 2'b01;
  localparam logic [1:0] PH_DONE = 2'b11;
  localparam logic [1:0] PH_BAD  = 2'b10;
endpackage

// File: rtl/bitstop_rst_sync.sv
module bitstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bitstop_ctrl.sv
module bitstop_ctrl
  import bitstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_flag_bit,
  input  logic       cnt_stop_bit,
  output logic [1:0] state,
  output logic       cmd_clear,
  output logic       cmd_inc,
  output logic       cmd_set_e,
  output logic       cmd_clr_e,
  output logic       cmd_set_f
);
  logic [1:0] state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cmd_clear = 1'b0;
    cmd_inc   = 1'b0;
    cmd_set_e = 1'b0;
    cmd_clr_e = 1'b0;
    cmd_set_f = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (start) begin
          cmd_clear = 1'b1;
          state_d   = PH_RUN;
        end
      end
      PH_RUN: begin
        cmd_inc = 1'b1;
        if (!cnt_flag_bit) begin
          cmd_clr_e = 1'b1;
        end else begin
          cmd_set_e = 1'b1;
          if (cnt_stop_bit) state_d = PH_DONE;
        end
      end
      PH_DONE: begin
        cmd_set_f = 1'b1;
        state_d   = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE && !start) |=> state_q == PH_IDLE);
  assert_start_enters_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE && start) |=> state_q == PH_RUN);
  assert_stop_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RUN && cnt_flag_bit && cnt_stop_bit) |=> state_q == PH_DONE);
  assert_keep_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RUN && !cnt_flag_bit) |=> state_q == PH_RUN);
  assert_done_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DONE) |=> state_q == PH_IDLE);
  assert_no_unused_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != PH_BAD);
endmodule

// File: rtl/bitstop_datapath.sv
module bitstop_datapath
  import bitstop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_clear,
  input  logic             cmd_inc,
  input  logic             cmd_set_e,
  input  logic             cmd_clr_e,
  input  logic             cmd_set_f,
  output logic [CNT_W-1:0] count,
  output logic             flag_e,
  output logic             flag_f
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, e_en, e_d, f_en, f_d;

  always_comb begin
    cnt_en = cmd_clear | cmd_inc;
    cnt_d  = cmd_clear ? '0 : cnt_q + CNT_W'(1);
    e_en   = cmd_set_e | cmd_clr_e;
    e_d    = cmd_set_e;
    f_en   = cmd_clear | cmd_set_f;
    f_d    = cmd_set_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_e <= 1'b0;
      flag_f <= 1'b0;
    end else begin
      if (cnt_en) cnt_q  <= cnt_d;
      if (e_en)   flag_e <= e_d;
      if (f_en)   flag_f <= f_d;
    end
  end

  assign count = cnt_q;

  assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (cnt_q == '0 && !flag_f && flag_e == $past(flag_e)));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_inc |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_e_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inc && !cnt_q[FLAG_BIT]) |=> !flag_e);
  assert_e_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inc && cnt_q[FLAG_BIT]) |=> flag_e);
  assert_f_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set_f |=> (flag_f && $stable(cnt_q)));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_clear && !cmd_inc && !cmd_set_f) |=> ($stable(cnt_q) && $stable(flag_f)));
endmodule

// File: rtl/bitstop_sequencer.sv
module bitstop_sequencer
  import bitstop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] count,
  output logic             flag_e,
  output logic             flag_f,
  output logic [1:0]       phase
);
  logic rst_n_sync;
  logic cmd_clear, cmd_inc, cmd_set_e, cmd_clr_e, cmd_set_f;

  bitstop_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  bitstop_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .start        (start),
    .cnt_flag_bit (count[FLAG_BIT]),
    .cnt_stop_bit (count[STOP_BIT]),
    .state        (phase),
    .cmd_clear    (cmd_clear),
    .cmd_inc      (cmd_inc),
    .cmd_set_e    (cmd_set_e),
    .cmd_clr_e    (cmd_clr_e),
    .cmd_set_f    (cmd_set_f)
  );

  bitstop_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cmd_clear (cmd_clear),
    .cmd_inc   (cmd_inc),
    .cmd_set_e (cmd_set_e),
    .cmd_clr_e (cmd_clr_e),
    .cmd_set_f (cmd_set_f),
    .count     (count),
    .flag_e    (flag_e),
    .flag_f    (flag_f)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (phase == PH_IDLE && count == '0 && !flag_e && !flag_f));
  assert_run_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phase == PH_RUN && count != '0) |-> $past(phase) == PH_RUN);
endmodule

// File: tb/bitstop_sequencer_bench.sv
module bitstop_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] count;
  logic       flag_e, flag_f;
  logic [1:0] phase;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int m_cnt, m_e, m_f, m_ph, m_prev_ph;

  always #4 clk = ~clk;

  bitstop_sequencer u_bitstop_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .count(count), .flag_e(flag_e), .flag_f(flag_f), .phase(phase)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_e = 0; m_f = 0; m_ph = 0; m_prev_ph = 0;
    end else begin
      m_prev_ph = m_ph;
      case (m_ph)
        0: if (start) begin m_cnt = 0; m_f = 0; m_ph = 1; end
        1: begin
          if (((m_cnt >> 2) & 1) == 0) m_e = 0;
          else begin
            m_e = 1;
            if (((m_cnt >> 3) & 1) == 1) m_ph = 3;
          end
          m_cnt = (m_cnt + 1) % 16;
        end
        default: begin m_f = 1; m_ph = 0; end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    string tc, te;
    @(negedge clk);
    tc = (m_prev_ph == 0) ? "R2/R3" : (m_prev_ph == 1) ? "R4" : "R7";
    te = (m_prev_ph == 1) ? "R5/R6" : "R3/R7";
    chk({tc, " count"}, count, m_cnt);
    chk({te, " flag_e"}, flag_e, m_e);
    chk("R3/R7 flag_f", flag_f, m_f);
    chk("R8/R10 phase", phase, m_ph);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int runlen;
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 phase", phase, 0);
    chk("R1 count", count, 0);
    chk("R1 flag_e", flag_e, 0);
    chk("R1 flag_f", flag_f, 0);
    rst_n = 1'b1;
    // R2: idle hold
    repeat (20) step();
    // R9: single start pulse
    start = 1'b1;
    step();
    start = 1'b0;
    runlen = (phase == 2'b01) ? 1 : 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (phase == 2'b01) runlen++;
    end
    chk("R9 run length", runlen, 13);
    chk("R9 final count", count, 13);
    chk("R9 final flag_e", flag_e, 1);
    chk("R9 final flag_f", flag_f, 1);
    chk("R9 final phase", phase, 0);
    // R10: start held high over several runs; flag_e carried into a new run
    start = 1'b1;
    for (int i = 0; i < 48; i++) step();
    // R10: toggling start patterns
    for (int i = 0; i < 90; i++) begin
      start = ((i % 3) == 0) || ((i % 7) == 2);
      step();
    end
    start = 1'b0;
    repeat (20) step();
    // R1: reset during counting
    start = 1'b1;
    step();
    start = 1'b0;
    repeat (5) step();
    rst_n = 1'b0;
    #1;
    chk("R1 midrun phase", phase, 0);
    chk("R1 midrun count", count, 0);
    chk("R1 midrun flag_e", flag_e, 0);
    chk("R1 midrun flag_f", flag_f, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) step();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule